// File: doc/BRIEF.md
# Multi-dimensional element index remapper

This block turns the plain step count of a vector loop into a reordered sequence of element indices. The loop of VL steps is treated as up to three nested loops over dimensions x, y and z. A 32-bit shape word sets the size of each dimension, which dimension loops innermost, whether each dimension counts down, which dimension is left out of the index, and a constant added to every index. Sizes need not be powers of two.

A start strobe captures the shape word and VL. The block then presents one index per cycle on a valid/ready handshake and pulses done when the step that completes VL is accepted. An all-zero shape word gives the plain step count. A shape word that selects anything other than the matrix reordering is flagged and produces no indices.

Top module: `elem_index_remap`

## Requirements
- R1: Shape word layout: bits 5:0, 11:6 and 17:12 hold the x, y and z sizes minus one; 20:18 nest order; 23:21 reversal (bit 21 for x, 22 for y, 23 for z); 27:24 offset; 29:28 skip; 31:30 mode, where 00 is the supported mode. Each index is the sum over kept dimensions of the dimension's position times a weight: 1 for x, the x size for y, the x size times the y size for z, where a left-out dimension counts as size 1 in these products.
- R2: The nest order field names the dimensions from innermost to outermost: 000 x,y,z; 001 x,z,y; 010 y,x,z; 011 y,z,x; 100 z,x,y; 101 z,y,x. The innermost dimension advances every step and each outer one advances when all inner ones wrap.
- R3: With its reversal bit set, a dimension's position runs from its size minus one down to 0 instead of from 0 up.
- R4: Skip value 01 leaves x out of the index, 10 leaves y out, 11 leaves z out, and 00 keeps all three.
- R5: The offset field is added to every produced index.
- R6: An all-zero shape word makes the index equal to the step number, 0 to VL-1.
- R7: When all dimensions wrap before VL steps are taken, the sequence starts again from its first index.
- R8: valid_o rises in the cycle after a start with non-zero VL and a supported shape; each cycle with valid_o and ready_i high accepts one index, and while ready_i is low the index and valid_o hold.
- R9: done_o is high only in the cycle where step VL-1 is accepted; valid_o is low in the following cycle unless a new start arrives.
- R10: A captured shape whose mode is not 00, or whose nest order is 110 or 111, raises unsupported_o from the cycle after the start until the next start, and valid_o stays low.
- R11: A start strobe has priority over an accepted step: it reloads all counters so the next index is the first of the new sequence and done_o does not pulse; a start with VL of 0 produces no index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Capture shape and VL, restart the sequence |
| shape_i | input | 32 | Shape word |
| vl_i | input | VL_W (7) | Number of steps, at most 127 |
| ready_i | input | 1 | Consumer accepts the current index |
| valid_o | output | 1 | index_o holds a step's index |
| index_o | output | IDX_W (20) | Remapped element index |
| done_o | output | 1 | Last step accepted this cycle |
| unsupported_o | output | 1 | Captured shape is not a matrix reordering |

## Verification
The case that needs care is a start strobe landing in the same cycle as an accepted step, in particular the final one that would raise done. The bench runs a transposing sequence part way with ready held high, raises start together with a different shape, and judges that done_o stays low in that cycle and that the next index shown is the first of the new shape rather than the next of the old. A single-step VL also puts the first and last step in the same cycle, checked by done_o rising with the very first index.

// File: rtl/remap_pkg.sv
// Package: shared field widths and the shape word structure for the
// element index remapper. Assumes a fixed 32-bit shape word.
package remap_pkg;

    localparam int NDIM        = 3;
    localparam int DIM_FIELD_W = 6;
    localparam int OFFSET_W    = 4;
    localparam int SHAPE_W     = 32;

    // Field order follows the shape word from bit 31 down to bit 0.
    typedef struct packed {
        logic [1:0]             mode;
        logic [1:0]             skip;
        logic [OFFSET_W-1:0]    offset;
        logic [NDIM-1:0]        rev;
        logic [2:0]             nest;
        logic [DIM_FIELD_W-1:0] zlast;
        logic [DIM_FIELD_W-1:0] ylast;
        logic [DIM_FIELD_W-1:0] xlast;
    } shape_t;

endpackage

// File: rtl/remap_shape_decode.sv
// Shape decoder: splits a captured shape word into per-dimension last
// values, nest positions and index weights, and flags shapes that are
// not a matrix reordering. Purely combinational; assumes IDX_W is wide
// enough for the product of the x and y sizes.
module remap_shape_decode
    import remap_pkg::*;
#(
    parameter int IDX_W = 20
) (
    input  shape_t                               shape_i,
    output logic [NDIM-1:0][DIM_FIELD_W-1:0]     last_o,
    output logic [NDIM-1:0][1:0]                 pos_o,
    output logic [NDIM-1:0][IDX_W-1:0]           weight_o,
    output logic                                 linear_o,
    output logic                                 unsupported_o
);

    logic [NDIM-1:0] keep;

    // Gather the per-dimension last values in x, y, z order.
    always_comb begin
        last_o[0] = shape_i.xlast;
        last_o[1] = shape_i.ylast;
        last_o[2] = shape_i.zlast;
    end

    // Nest position of each dimension, 0 = innermost.
    always_comb begin
        case (shape_i.nest)
            3'b001:  pos_o = {2'd1, 2'd2, 2'd0};
            3'b010:  pos_o = {2'd2, 2'd0, 2'd1};
            3'b011:  pos_o = {2'd1, 2'd0, 2'd2};
            3'b100:  pos_o = {2'd0, 2'd2, 2'd1};
            3'b101:  pos_o = {2'd0, 2'd1, 2'd2};
            default: pos_o = {2'd2, 2'd1, 2'd0};
        endcase
    end

    // Mark which dimensions contribute to the index.
    generate
        for (genvar d = 0; d < NDIM; d++) begin : g_keep
            assign keep[d] = (shape_i.skip != 2'(d + 1));
        end
    endgenerate

    // Weights follow the array layout: each kept dimension is scaled by
    // the product of the kept sizes of the lower-numbered dimensions.
    always_comb begin
        logic [IDX_W-1:0] run;
        run = IDX_W'(1);
        for (int d = 0; d < NDIM; d++) begin
            weight_o[d] = keep[d] ? run : '0;
            if (keep[d]) begin
                run = run * (IDX_W'(last_o[d]) + IDX_W'(1));
            end
        end
    end

    // Mode checks: all-zero word is linear, other modes are rejected.
    always_comb begin
        linear_o      = (shape_i == '0);
        unsupported_o = (shape_i.mode != 2'b00) || (shape_i.nest[2:1] == 2'b11);
    end

endmodule

// File: rtl/remap_dim_counter.sv
// Dimension counter: counts one loop dimension from 0 to its last value
// and wraps to 0. Assumes clear and increment are never needed together
// beyond clear winning.
module remap_dim_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         inc_i,
    input  logic [W-1:0] last_i,
    output logic [W-1:0] value_o,
    output logic         at_last_o
);

    // Hold, clear or step the dimension position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_o <= '0;
        end else if (clear_i) begin
            value_o <= '0;
        end else if (inc_i) begin
            value_o <= (value_o == last_i) ? '0 : value_o + W'(1);
        end
    end

    // Flag the final position so outer dimensions can carry.
    assign at_last_o = (value_o == last_i);

endmodule

// File: rtl/remap_index_compose.sv
// Index composer: applies per-dimension reversal, weights and offset to
// the counter positions, or passes the step number for a linear shape.
// Combinational; assumes IDX_W is at least VL_W.
module remap_index_compose
    import remap_pkg::*;
#(
    parameter int IDX_W = 20,
    parameter int VL_W  = 7
) (
    input  logic [NDIM-1:0][DIM_FIELD_W-1:0] pos_val_i,
    input  logic [NDIM-1:0][DIM_FIELD_W-1:0] last_i,
    input  logic [NDIM-1:0]                  rev_i,
    input  logic [NDIM-1:0][IDX_W-1:0]       weight_i,
    input  logic [OFFSET_W-1:0]              offset_i,
    input  logic                             linear_i,
    input  logic [VL_W-1:0]                  step_i,
    output logic [IDX_W-1:0]                 index_o
);

    logic [NDIM-1:0][DIM_FIELD_W-1:0] eff;

    // Turn each counter into its effective, possibly reversed, position.
    generate
        for (genvar d = 0; d < NDIM; d++) begin : g_eff
            assign eff[d] = rev_i[d] ? (last_i[d] - pos_val_i[d]) : pos_val_i[d];
        end
    endgenerate

    // Weighted sum plus offset, or the plain step number.
    always_comb begin
        logic [IDX_W-1:0] acc;
        acc = IDX_W'(offset_i);
        for (int d = 0; d < NDIM; d++) begin
            acc = acc + IDX_W'(eff[d]) * weight_i[d];
        end
        index_o = linear_i ? IDX_W'(step_i) : acc;
    end

endmodule

// File: rtl/elem_index_remap.sv
// Element index remapper top: captures a shape word and VL on start,
// steps three nested dimension counters one position per accepted
// index, and reports the last step. Assumes VL_W <= IDX_W.
module elem_index_remap
    import remap_pkg::*;
#(
    parameter int VL_W  = 7,
    parameter int IDX_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SHAPE_W-1:0]  shape_i,
    input  logic [VL_W-1:0]     vl_i,
    input  logic                ready_i,
    output logic                valid_o,
    output logic [IDX_W-1:0]    index_o,
    output logic                done_o,
    output logic                unsupported_o
);

    shape_t                            shape_q;
    logic [VL_W-1:0]                   vl_q;
    logic [VL_W-1:0]                   step_q;
    logic                              running_q;

    logic [NDIM-1:0][DIM_FIELD_W-1:0]  last_v;
    logic [NDIM-1:0][1:0]              pos_v;
    logic [NDIM-1:0][IDX_W-1:0]        weight_v;
    logic                              linear;
    logic                              bad_shape;
    logic [NDIM-1:0][DIM_FIELD_W-1:0]  cnt_v;
    logic [NDIM-1:0]                   at_last_v;
    logic [NDIM-1:0]                   inc_v;
    logic                              advance;
    logic                              last_step;

    remap_shape_decode #(.IDX_W(IDX_W)) u_decode (
        .shape_i       (shape_q),
        .last_o        (last_v),
        .pos_o         (pos_v),
        .weight_o      (weight_v),
        .linear_o      (linear),
        .unsupported_o (bad_shape)
    );

    // Handshake terms: a step is taken only when no start overrides it.
    assign valid_o       = running_q && !bad_shape;
    assign last_step     = (step_q == vl_q - VL_W'(1));
    assign advance       = valid_o && ready_i && !start_i;
    assign done_o        = advance && last_step;
    assign unsupported_o = bad_shape;

    // Capture configuration on start and track the step number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shape_q   <= '0;
            vl_q      <= '0;
            step_q    <= '0;
            running_q <= 1'b0;
        end else if (start_i) begin
            shape_q   <= shape_t'(shape_i);
            vl_q      <= vl_i;
            step_q    <= '0;
            running_q <= (vl_i != '0);
        end else if (advance) begin
            step_q <= step_q + VL_W'(1);
            if (last_step) begin
                running_q <= 1'b0;
            end
        end
    end

    generate
        for (genvar d = 0; d < NDIM; d++) begin : g_dim
            // A dimension steps when every dimension nested inside it wraps.
            always_comb begin
                inc_v[d] = advance;
                for (int e = 0; e < NDIM; e++) begin
                    if ((e != d) && (pos_v[e] < pos_v[d])) begin
                        inc_v[d] = inc_v[d] & at_last_v[e];
                    end
                end
            end

            remap_dim_counter #(.W(DIM_FIELD_W)) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear_i   (start_i),
                .inc_i     (inc_v[d]),
                .last_i    (last_v[d]),
                .value_o   (cnt_v[d]),
                .at_last_o (at_last_v[d])
            );
        end
    endgenerate

    remap_index_compose #(.IDX_W(IDX_W), .VL_W(VL_W)) u_compose (
        .pos_val_i (cnt_v),
        .last_i    (last_v),
        .rev_i     (shape_q.rev),
        .weight_i  (weight_v),
        .offset_i  (shape_q.offset),
        .linear_i  (linear),
        .step_i    (step_q),
        .index_o   (index_o)
    );

endmodule

// File: rtl/elem_index_remap_checker.sv
// Checker for the element index remapper: watches the top-level ports,
// keeps its own step count since the last start, and checks handshake,
// completion and linear-mode rules. Attached by bind below.
module elem_index_remap_checker #(
    parameter int VL_W  = 7,
    parameter int IDX_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [31:0]      shape_i,
    input logic [VL_W-1:0]  vl_i,
    input logic             ready_i,
    input logic             valid_o,
    input logic [IDX_W-1:0] index_o,
    input logic             done_o,
    input logic             unsupported_o
);

    logic [VL_W-1:0] seen_q;
    logic [VL_W-1:0] vl_cap_q;
    logic            lin_cap_q;

    // Independent record of accepted steps since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q    <= '0;
            vl_cap_q  <= '0;
            lin_cap_q <= 1'b0;
        end else if (start_i) begin
            seen_q    <= '0;
            vl_cap_q  <= vl_i;
            lin_cap_q <= (shape_i == 32'h0);
        end else if (valid_o && ready_i) begin
            seen_q <= seen_q + VL_W'(1);
        end
    end

    AST_DONE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (valid_o && ready_i && !start_i)) else $error("done without accept"); // R9

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !valid_o) else $error("valid after done"); // R9

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !start_i) |=> (valid_o && $stable(index_o))) else $error("stall not held"); // R8

    AST_UNSUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported_o |-> !valid_o) else $error("valid on unsupported shape"); // R10

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && lin_cap_q) |-> (index_o == IDX_W'(seen_q))) else $error("linear index wrong"); // R6

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (seen_q < vl_cap_q)) else $error("more than VL steps"); // R11

endmodule

bind elem_index_remap elem_index_remap_checker #(.VL_W(VL_W), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .shape_i       (shape_i),
    .vl_i          (vl_i),
    .ready_i       (ready_i),
    .valid_o       (valid_o),
    .index_o       (index_o),
    .done_o        (done_o),
    .unsupported_o (unsupported_o)
);

// File: tb/tb_elem_index_remap.sv
`timescale 1ns/1ps
// Bench: walks a table of shapes with hand-derived index sequences, then
// directed tests for reset, stall, restart, VL extremes and rejection.
module tb_elem_index_remap;

    localparam int VL_W  = 7;
    localparam int IDX_W = 20;
    localparam int NV    = 11;

    // {shape word, six expected indices (first in the top byte)}
    localparam logic [79:0] TABLE [NV] = '{
        {2'b00, 2'b00, 4'd0, 3'b000, 3'b000, 6'd0, 6'd0, 6'd0, 8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5},
        {2'b00, 2'b00, 4'd0, 3'b000, 3'b010, 6'd0, 6'd2, 6'd2, 8'd0, 8'd3, 8'd6, 8'd1, 8'd4, 8'd7},
        {2'b00, 2'b00, 4'd0, 3'b001, 3'b000, 6'd0, 6'd2, 6'd2, 8'd2, 8'd1, 8'd0, 8'd5, 8'd4, 8'd3},
        {2'b00, 2'b01, 4'd0, 3'b000, 3'b000, 6'd0, 6'd2, 6'd2, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1},
        {2'b00, 2'b10, 4'd0, 3'b000, 3'b000, 6'd0, 6'd2, 6'd2, 8'd0, 8'd1, 8'd2, 8'd0, 8'd1, 8'd2},
        {2'b00, 2'b00, 4'd0, 3'b000, 3'b100, 6'd2, 6'd0, 6'd1, 8'd0, 8'd2, 8'd4, 8'd1, 8'd3, 8'd5},
        {2'b00, 2'b00, 4'd5, 3'b000, 3'b000, 6'd0, 6'd0, 6'd3, 8'd5, 8'd6, 8'd7, 8'd8, 8'd5, 8'd6},
        {2'b00, 2'b00, 4'd0, 3'b111, 3'b101, 6'd1, 6'd1, 6'd1, 8'd7, 8'd3, 8'd5, 8'd1, 8'd6, 8'd2},
        {2'b00, 2'b00, 4'd0, 3'b000, 3'b011, 6'd1, 6'd1, 6'd1, 8'd0, 8'd2, 8'd4, 8'd6, 8'd1, 8'd3},
        {2'b00, 2'b00, 4'd0, 3'b000, 3'b001, 6'd1, 6'd1, 6'd1, 8'd0, 8'd1, 8'd4, 8'd5, 8'd2, 8'd3},
        {2'b00, 2'b11, 4'd0, 3'b000, 3'b001, 6'd1, 6'd0, 6'd1, 8'd0, 8'd1, 8'd0, 8'd1, 8'd0, 8'd1}
    };
    localparam string TAGS [NV] = '{
        "R6 linear", "R2 transpose", "R3 reverse x", "R4 skip x", "R4 skip y",
        "R1 z innermost", "R5/R7 offset wrap", "R3 reverse all", "R2 order 011",
        "R2 order 001", "R4 skip z"
    };

    localparam logic [31:0] SH_TRANS = TABLE[1][79:48];
    localparam logic [31:0] SH_REVX  = TABLE[2][79:48];

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [31:0]      shape_i = '0;
    logic [VL_W-1:0]  vl_i = '0;
    logic             ready_i = 1'b0;
    logic             valid_o;
    logic [IDX_W-1:0] index_o;
    logic             done_o;
    logic             unsupported_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    elem_index_remap #(.VL_W(VL_W), .IDX_W(IDX_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .shape_i       (shape_i),
        .vl_i          (vl_i),
        .ready_i       (ready_i),
        .valid_o       (valid_o),
        .index_o       (index_o),
        .done_o        (done_o),
        .unsupported_o (unsupported_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Raise start for one cycle with the given shape and VL, ready low.
    task automatic kick(input logic [31:0] sh, input int vl);
        @(negedge clk);
        start_i = 1'b1;
        shape_i = sh;
        vl_i    = VL_W'(vl);
        ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state (R8, R9, R10)
        repeat (3) @(negedge clk);
        #1;
        check(valid_o == 1'b0, "R8 reset valid", int'(valid_o), 0);
        check(done_o == 1'b0, "R9 reset done", int'(done_o), 0);
        check(unsupported_o == 1'b0, "R10 reset unsupported", int'(unsupported_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: six steps per shape with ready held high.
        for (int t = 0; t < NV; t++) begin
            kick(TABLE[t][79:48], 6);
            ready_i = 1'b1;
            for (int k = 0; k < 6; k++) begin
                check(valid_o == 1'b1, TAGS[t], int'(valid_o), 1);
                check(index_o == IDX_W'(TABLE[t][47 - 8*k -: 8]), TAGS[t],
                      int'(index_o), int'(TABLE[t][47 - 8*k -: 8]));
                check(done_o == (k == 5), "R9 done position", int'(done_o), int'(k == 5));
                @(negedge clk);
                #1;
            end
            check(valid_o == 1'b0, "R9 idle after done", int'(valid_o), 0);
            ready_i = 1'b0;
        end

        // Stall holds the index (R8)
        kick(SH_TRANS, 6);
        check(valid_o == 1'b1 && index_o == 0, "R8 first index before ready", int'(index_o), 0);
        @(negedge clk);
        #1;
        check(valid_o == 1'b1 && index_o == 0, "R8 held while stalled", int'(index_o), 0);
        ready_i = 1'b1;
        @(negedge clk);
        #1;
        check(index_o == 3, "R8 advance after ready", int'(index_o), 3);

        // Start in the same cycle as an accepted step (R11)
        @(negedge clk);
        #1;
        check(index_o == 6, "R2 third transposed index", int'(index_o), 6);
        @(negedge clk);
        start_i = 1'b1;
        shape_i = SH_REVX;
        vl_i    = VL_W'(6);
        #1;
        check(done_o == 1'b0, "R11 no done on restart", int'(done_o), 0);
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(index_o == 2, "R11 restart first index", int'(index_o), 2);
        @(negedge clk);
        #1;
        check(index_o == 1, "R11 restart second index", int'(index_o), 1);
        ready_i = 1'b0;

        // Single step: first and last coincide (R9)
        kick(32'h0, 1);
        ready_i = 1'b1;
        #0;
        check(done_o == 1'b1 && index_o == 0, "R9 single step done", int'(done_o), 1);
        @(negedge clk);
        #1;
        check(valid_o == 1'b0, "R9 single step idle", int'(valid_o), 0);
        ready_i = 1'b0;

        // VL of zero yields nothing (R11)
        kick(SH_TRANS, 0);
        ready_i = 1'b1;
        #0;
        check(valid_o == 1'b0, "R11 zero VL", int'(valid_o), 0);
        ready_i = 1'b0;

        // Maximum VL on a linear shape (R6, R9)
        begin
            int bad_idx;
            int done_at;
            bad_idx = 0;
            done_at = -1;
            kick(32'h0, 127);
            ready_i = 1'b1;
            for (int k = 0; k < 127; k++) begin
                if (index_o != IDX_W'(k) || !valid_o) bad_idx++;
                if (done_o) done_at = k;
                @(negedge clk);
                #1;
            end
            check(bad_idx == 0, "R6 linear 127 steps", bad_idx, 0);
            check(done_at == 126, "R9 done at step 126", done_at, 126);
            check(valid_o == 1'b0, "R9 idle after 127", int'(valid_o), 0);
            ready_i = 1'b0;
        end

        // Rejected shapes (R10)
        kick({2'b00, 2'b00, 4'd0, 3'b000, 3'b110, 6'd0, 6'd2, 6'd2}, 6);
        ready_i = 1'b1;
        #0;
        check(unsupported_o == 1'b1, "R10 order 110 flagged", int'(unsupported_o), 1);
        check(valid_o == 1'b0, "R10 order 110 silent", int'(valid_o), 0);
        ready_i = 1'b0;
        kick({2'b01, 2'b00, 4'd0, 3'b000, 3'b000, 6'd0, 6'd0, 6'd3}, 6);
        check(unsupported_o == 1'b1, "R10 mode 01 flagged", int'(unsupported_o), 1);
        kick(32'h0, 3);
        check(unsupported_o == 1'b0, "R10 cleared by start", int'(unsupported_o), 0);
        check(valid_o == 1'b1, "R8 valid after start", int'(valid_o), 1);

        finish_run();
    end

endmodule